// File: doc/BRIEF.md
# Programmable ADC Step Sequencer

This block drives an external analog-to-digital converter through a list of up to `STEPS` programmed sample steps. Software first writes two nibble words. In the input-select word, nibble *i* picks the channel for step *i*. In the control word, nibble *i* sets the options for that step. Software then sets the enable bit. Each rising of the trigger input while the block is enabled and idle starts a pass through the list at step 0.

For each step the block presents a channel number, a differential flag and a temperature-sensor flag, and holds a conversion request until the converter answers with a one-cycle done strobe carrying a 10-bit result. The result is placed in a circular FIFO that holds as many entries as there are steps. Software pops that FIFO by reading one data address.

Per-step interrupt enables feed a sticky interrupt flag. Overflow and underflow are also recorded in sticky flags, and all three clear when software writes 1 to them. The head pointer, tail pointer, empty flag, full flag and busy flag are readable as status. A register port with separate write and read strobes gives access to all of this. Reads return data in the same cycle, and a read of the data address removes an entry at the following clock edge.

Top module: `adc_step_sequencer`

## Requirements
- R1: After reset, conv_req and irq are 0. The status word (address 4) reads empty=1 (bit 8), full=0 (bit 9), busy=0 (bit 10), head=0 (bits 3:0) and tail=0 (bits 7:4). The flag word (address 5) reads 0.
- R2: A trigger is ignored when the enable bit (address 0, bit 0) is 0. A trigger is also ignored while a pass is running: it neither restarts the pass nor adds steps.
- R3: During step i, conv_chan equals nibble i of the select word (address 1). conv_diff equals bit 0 of control nibble i (address 2), and conv_temp equals bit 3 of that nibble. conv_req stays high, with these outputs held, until conv_done. Several steps may select the same channel.
- R4: A pass ends after the first executed step whose control nibble has bit 1 (END) set. If no executed step has END set, the pass ends after step STEPS-1.
- R5: Each result is stored as a 32-bit word with the value in bits 9:0 and zeros above. Reads of address 3 return the stored results oldest first, and each such read removes the entry it returned.
- R6: The status word tracks head (advanced by each stored result, modulo STEPS) and tail (advanced by each pop, modulo STEPS). Full is set when STEPS entries are held, and empty is set when none are held.
- R7: A result that arrives while the FIFO is full is discarded, and the overflow flag (address 5, bit 0) is set. The stored entries and the head pointer stay as they were.
- R8: A read of address 3 while the FIFO is empty returns 0, leaves both pointers as they were, and sets the underflow flag (address 5, bit 1).
- R9: A completed step whose control nibble has bit 2 set raises the interrupt flag (address 5, bit 2), and irq follows that flag. Steps without bit 2 set do not raise it.
- R10: Writing to address 5 clears each flag whose bit is 1 in the written data and leaves the others unchanged. If a flag is cleared and set in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| trigger | input | 1 | Start request for a pass |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 4 | Channel for the current step |
| conv_diff | output | 1 | Differential mode for the current step |
| conv_temp | output | 1 | Temperature sensor select for the current step |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | RES_W | Conversion result |
| irq | output | 1 | Interrupt, level of the sticky interrupt flag |

## Verification
A wrong step index shows up on conv_chan, conv_diff and conv_temp in the very cycle the request is raised, so the converter model records those values at every request. A fault in the end-of-pass logic changes the number of requests issued, and the bench sees this as soon as busy drops. Pointer or count faults in the FIFO first show in the status word and later as results popped in the wrong order or with the wrong value. The overflow and underflow paths are driven on purpose, so a missed discard or a pointer moved on an empty read appears in the very next status read.

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer #(
  parameter int STEPS = 8,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             trigger,
  output logic             conv_req,
  output logic [3:0]       conv_chan,
  output logic             conv_diff,
  output logic             conv_temp,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             irq
);
  localparam int PW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int CW = $clog2(STEPS + 1);
  localparam int NW = 4 * STEPS;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_SEL  = 3'd1;
  localparam logic [2:0] A_OPT  = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_FLAG = 3'd5;

  logic             enable;
  logic [NW-1:0]    sel_r, opt_r;
  logic             busy;
  logic [PW-1:0]    step;
  logic [RES_W-1:0] mem [STEPS];
  logic [PW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic             ovf, unf, ist;

  logic [3:0] cur_opt;
  logic       last, start, push, full, empty, do_push, do_pop, pop_req, flag_wr;

  assign cur_opt  = opt_r[4*step +: 4];
  assign last     = cur_opt[1] || (step == PW'(STEPS - 1));
  assign start    = trigger && enable && !busy;
  assign push     = busy && conv_done;
  assign full     = (count == CW'(STEPS));
  assign empty    = (count == '0);
  assign do_push  = push && !full;
  assign pop_req  = bus_rd && (bus_addr == A_DATA);
  assign do_pop   = pop_req && !empty;
  assign flag_wr  = bus_wr && (bus_addr == A_FLAG);

  assign conv_req  = busy;
  assign conv_chan = sel_r[4*step +: 4];
  assign conv_diff = cur_opt[0];
  assign conv_temp = cur_opt[3];
  assign irq       = ist;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(STEPS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      sel_r  <= '0;
      opt_r  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  enable <= bus_wdata[0];
        A_SEL:   sel_r  <= bus_wdata[NW-1:0];
        A_OPT:   opt_r  <= bus_wdata[NW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (push) begin
      if (last) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[head] <= conv_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (do_push) head <= wrap_inc(head);
      if (do_pop)  tail <= wrap_inc(tail);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
      ist <= 1'b0;
    end else begin
      ovf <= (ovf && !(flag_wr && bus_wdata[0])) || (push && full);
      unf <= (unf && !(flag_wr && bus_wdata[1])) || (pop_req && empty);
      ist <= (ist && !(flag_wr && bus_wdata[2])) || (push && cur_opt[2]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0] = enable;
      A_SEL:  bus_rdata[NW-1:0] = sel_r;
      A_OPT:  bus_rdata[NW-1:0] = opt_r;
      A_DATA: if (!empty) bus_rdata[RES_W-1:0] = mem[tail];
      A_STAT: begin
        bus_rdata[3:0] = 4'(head);
        bus_rdata[7:4] = 4'(tail);
        bus_rdata[8]   = empty;
        bus_rdata[9]   = full;
        bus_rdata[10]  = busy;
      end
      A_FLAG: bus_rdata[2:0] = {ist, unf, ovf};
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_step_sequencer_chk.sv
module adc_step_sequencer_chk #(
  parameter int STEPS = 8,
  parameter int PW = 3,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_req,
  input logic          conv_done,
  input logic [3:0]    conv_chan,
  input logic          trigger,
  input logic          busy,
  input logic [PW-1:0] step,
  input logic [CW-1:0] count,
  input logic [PW-1:0] head,
  input logic [3:0]    cur_opt,
  input logic          bus_rd,
  input logic [2:0]    bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          ovf,
  input logic          irq
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req && $stable(conv_chan));

  // R2
  retrig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trigger && !conv_done |=> busy && $stable(step));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(STEPS));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && conv_done && count == CW'(STEPS) && !(bus_rd && bus_addr == 3'd3)
    |=> ovf && $stable(head) && count == CW'(STEPS));

  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 3'd3 && count == '0 |-> bus_rdata == 32'd0);

  // R9
  step_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && conv_done && cur_opt[2] |=> irq);
endmodule

bind adc_step_sequencer adc_step_sequencer_chk #(.STEPS(STEPS), .PW(PW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_done(conv_done),
  .conv_chan(conv_chan), .trigger(trigger), .busy(busy), .step(step),
  .count(count), .head(head), .cur_opt(cur_opt), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ovf(ovf), .irq(irq)
);

// File: tb/adc_step_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_step_sequencer_tb_top;
  localparam int STEPS = 8;
  localparam int RES_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, trigger = 0, conv_done = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic conv_req, conv_diff, conv_temp, irq;
  logic [3:0] conv_chan;
  logic [RES_W-1:0] conv_data = '0;

  always #4 clk = ~clk;

  adc_step_sequencer #(.STEPS(STEPS), .RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trigger(trigger),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_diff(conv_diff),
    .conv_temp(conv_temp), .conv_done(conv_done), .conv_data(conv_data), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int ncv = 0, ntot = 0, hd = 0, tl = 0;
  logic [3:0] o_chan [64];
  logic o_diff [64], o_temp [64];
  logic [RES_W-1:0] mq [$];

  // mux word, control word, expected step count
  localparam logic [71:0] VEC [0:3] = '{
    {32'h7654_3210, 32'h0000_0000, 8'd8},
    {32'h3333_3333, 32'h0002_0089, 8'd5},
    {32'hA5A5_A5A5, 32'h0000_0002, 8'd1},
    {32'h0F0F_0F0F, 32'h1111_1135, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
    if (a == 3'd3 && d != 0) tl = (tl + 1) % STEPS;
  endtask

  task automatic fire();
    @(negedge clk); trigger = 1;
    @(negedge clk); trigger = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(3'd4, s); while (s[10]);
  endtask

  task automatic chk_status(input string req);
    logic [31:0] s;
    rd(3'd4, s);
    chk(s[3:0] == 4'(hd), req, s[3:0], hd);
    chk(s[7:4] == 4'(tl), req, s[7:4], tl);
    chk(s[8] == (mq.size() == 0), req, s[8], mq.size() == 0);
    chk(s[9] == (mq.size() == STEPS), req, s[9], mq.size() == STEPS);
  endtask

  task automatic pop_all(input string req);
    logic [31:0] d;
    while (mq.size() > 0) begin
      logic [RES_W-1:0] e;
      e = mq.pop_front();
      rd(3'd3, d);
      chk(d == 32'(e), req, d, e);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        logic [RES_W-1:0] v;
        o_chan[ncv] = conv_chan; o_diff[ncv] = conv_diff; o_temp[ncv] = conv_temp;
        repeat (2) @(negedge clk);
        v = RES_W'(ntot * 37 + 5 * conv_chan + 1);
        conv_data = v; conv_done = 1;
        if (mq.size() < STEPS) begin
          mq.push_back(v);
          hd = (hd + 1) % STEPS;
        end
        ncv++; ntot++;
        @(negedge clk); conv_done = 0;
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(conv_req == 0, "R1 conv_req", conv_req, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rd(3'd4, d);
    chk(d == 32'h100, "R1 status", d, 32'h100);
    rd(3'd5, d);
    chk(d == 0, "R1 flags", d, 0);

    // R2 trigger while disabled
    wr(3'd1, 32'h1234_5678);
    fire();
    repeat (6) @(negedge clk);
    chk(ncv == 0 && conv_req == 0, "R2 disabled trigger", ncv, 0);

    wr(3'd0, 32'h1);
    foreach (VEC[k]) begin
      logic [31:0] m, c;
      int n;
      bit exp_irq;
      m = VEC[k][71:40]; c = VEC[k][39:8]; n = int'(VEC[k][7:0]);
      wr(3'd1, m); wr(3'd2, c);
      ncv = 0;
      fire();
      wait_idle();
      chk(ncv == n, "R4 step count", ncv, n);
      exp_irq = 0;
      for (int i = 0; i < n; i++) begin
        chk(o_chan[i] == m[4*i +: 4], "R3 channel", o_chan[i], m[4*i +: 4]);
        chk(o_diff[i] == c[4*i], "R3 diff", o_diff[i], c[4*i]);
        chk(o_temp[i] == c[4*i+3], "R3 temp", o_temp[i], c[4*i+3]);
        if (c[4*i+2]) exp_irq = 1;
      end
      chk(irq == exp_irq, "R9 irq", irq, exp_irq);
      chk_status("R6 status after pass");
      pop_all("R5 pop order");
      chk_status("R6 status after drain");
      wr(3'd5, 32'h4);
      chk(irq == 0, "R10 irq clear", irq, 0);
    end

    // R2 retrigger during pass
    wr(3'd2, 32'h0);
    ncv = 0;
    fire();
    repeat (4) @(negedge clk);
    fire();
    wait_idle();
    chk(ncv == STEPS, "R2 busy trigger", ncv, STEPS);
    chk_status("R6 full");

    // R7 overflow
    wr(3'd2, 32'h2);
    ncv = 0;
    fire();
    wait_idle();
    chk(ncv == 1, "R7 extra step", ncv, 1);
    rd(3'd5, d);
    chk(d[0] == 1, "R7 overflow flag", d[0], 1);
    chk_status("R7 status unchanged");
    pop_all("R7 kept entries");

    // R8 underflow
    rd(3'd3, d);
    chk(d == 0, "R8 empty read", d, 0);
    chk_status("R8 pointers");
    rd(3'd5, d);
    chk(d[1:0] == 2'b11, "R8 underflow flag", d[1:0], 3);

    // R10 write-one-to-clear
    wr(3'd5, 32'h1);
    rd(3'd5, d);
    chk(d[2:0] == 3'b010, "R10 partial clear", d[2:0], 2);
    wr(3'd5, 32'h2);
    rd(3'd5, d);
    chk(d[2:0] == 3'b000, "R10 full clear", d[2:0], 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule